// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Read Controller

This block is the slave side of a two-wire serial bus placed in front of a 256-word by 8-bit memory array. A fast system clock samples the bus clock and data lines through synchronisers. The block finds START, repeated START and STOP conditions. It checks a fixed 7-bit device address and answers through an open-drain data line, given as a drive-low enable.

A word pointer inside the block keeps its value from one transaction to the next. A master can read the word that follows the last one touched without sending any address. A master can also load the pointer first, with a write-direction transaction that carries one word-address byte, then send a repeated START and read from that location. Any bytes sent after the word address are written to the memory and advance the pointer. A master that acknowledges each read byte keeps reading in sequence. A master that does not acknowledge ends the read.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: While reset is held and just after it, `sda_oe` is 0 and `mem_en` is 0.
- R2: A fall of the data line while the clock line is high is a START. It begins a new address byte from any state, including a repeated START in the middle of a transaction. A rise of the data line while the clock line is high is a STOP, and it returns the block to idle.
- R3: The first byte after a START is the 7-bit device address, MSB first, in bits 7..1, with the direction in bit 0 (1 = read). When the address equals `DEV_ADDR` (default 0x50), the block acknowledges by holding the data line low through the ninth clock.
- R4: When the address does not match, the data line stays high on the ninth clock. Until the next START the block then drives nothing, makes no memory access and leaves the word pointer unchanged.
- R5: In a write-direction transaction, the byte after the device address is a word address. The block acknowledges it and loads it into the word pointer.
- R6: After a read-direction address is acknowledged, the block sends the byte at the word pointer, MSB first. It changes the data line only while the clock line is low.
- R7: Each byte read or written advances the pointer by one. A read with no address phase therefore returns the word after the last one accessed.
- R8: When the master acknowledges a read byte, the next byte follows. The pointer wraps from 255 to 0.
- R9: When the master does not acknowledge a read byte, the block releases the data line and drives nothing more until the next START.
- R10: In a write-direction transaction, each byte after the word address is written to the memory at the pointer and acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When 1, pulls the data line low |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write select (1 = write) |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after a read strobe |

## Verification
Random reads start at varied addresses, including 0xFE, so that a multi-byte sequential read crosses the wrap and shows that the pointer rolls over instead of saturating. Current-address reads follow random reads, byte writes and rejected addresses. Each of these tells whether the pointer advanced on the right event, or was left alone. Transactions with a wrong device address, and bus clocks sent after a NACK, show whether the block keeps quiet when it is not addressed. An aborted address byte followed by a fresh START shows that a START resynchronises the block.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK1,
    ST_ACK2,
    ST_RD,
    ST_RDACK,
    ST_IGNORE
  } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  genvar gi;
  generate
    for (gi = 0; gi < LINES; gi++) begin : g_line
      logic [STAGES-1:0] chain_q;
      logic [STAGES-1:0] chain_d;

      always_comb begin
        chain_d = {chain_q[STAGES-2:0], din[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= chain_d;
        end
      end

      assign dout[gi] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    scl_rise  = scl_s & ~scl_q;
    scl_fall  = ~scl_s & scl_q;
    start_det = scl_s & scl_q & sda_q & ~sda_s;
    stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_word_ptr.sv
module i2c_word_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (ld) begin
      ptr_d = ld_val;
    end else if (inc) begin
      ptr_d = ptr + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (ld || inc) begin
      ptr <= ptr_d;
    end
  end

endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
  import i2c_eeprom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h50,
  parameter int         AW          = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              mem_en,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata
);

  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_ff;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff <= 2'b00;
    end else begin
      rst_ff <= {rst_ff[0], 1'b1};
    end
  end
  assign rst_ns = rst_ff[1];

  // line conditioning
  logic [1:0] lines_s;
  logic       scl_s;
  logic       sda_now;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;

  i2c_line_sync #(
    .STAGES (SYNC_STAGES),
    .LINES  (2)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_ns),
    .din   ({scl_i, sda_i}),
    .dout  (lines_s)
  );
  assign scl_s   = lines_s[1];
  assign sda_now = lines_s[0];

  i2c_cond_detect u_cond (
    .clk       (clk),
    .rst_n     (rst_ns),
    .scl_s     (scl_s),
    .sda_s     (sda_now),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  // word pointer
  logic          ptr_ld;
  logic          ptr_inc;
  logic [AW-1:0] ptr_ld_val;
  logic [AW-1:0] ptr;

  i2c_word_ptr #(
    .AW (AW)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_ns),
    .ld     (ptr_ld),
    .ld_val (ptr_ld_val),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );

  // protocol state
  slv_state_e        state, state_d;
  slv_state_e        nxt, nxt_d;
  logic [CW-1:0]     cnt, cnt_d;
  logic [BYTE_W-1:0] rx_sr, rx_d;
  logic [BYTE_W-1:0] tx_sr, tx_d;
  logic              ackf, ackf_d;
  logic              rd_pend, rd_pend_d;
  logic              oe_d;
  logic [BYTE_W-1:0] rx_byte;

  always_comb begin
    rx_byte    = {rx_sr[BYTE_W-2:0], sda_now};
    ptr_ld_val = rx_byte[AW-1:0];
    state_d    = state;
    nxt_d      = nxt;
    cnt_d      = cnt;
    rx_d       = rx_sr;
    tx_d       = rd_pend ? mem_rdata : tx_sr;
    ackf_d     = ackf;
    oe_d       = sda_oe;
    rd_pend_d  = 1'b0;
    mem_en     = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = ptr;
    mem_wdata  = rx_byte;
    ptr_ld     = 1'b0;
    ptr_inc    = 1'b0;

    if (start_det) begin
      state_d = ST_DEV;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            rx_d  = rx_byte;
            cnt_d = cnt + CW'(1);
            if (cnt == LAST_BIT) begin
              cnt_d   = '0;
              state_d = ST_ACK1;
              if (state == ST_DEV) begin
                if (rx_byte[BYTE_W-1:1] == DEV_ADDR) begin
                  if (rx_byte[0]) begin
                    mem_en    = 1'b1;
                    ptr_inc   = 1'b1;
                    rd_pend_d = 1'b1;
                    nxt_d     = ST_RD;
                  end else begin
                    nxt_d = ST_WADDR;
                  end
                end else begin
                  state_d = ST_IGNORE;
                end
              end else if (state == ST_WADDR) begin
                ptr_ld = 1'b1;
                nxt_d  = ST_WDATA;
              end else begin
                mem_en  = 1'b1;
                mem_we  = 1'b1;
                ptr_inc = 1'b1;
                nxt_d   = ST_WDATA;
              end
            end
          end
        end
        ST_ACK1: begin
          if (scl_fall) begin
            oe_d    = 1'b1;
            state_d = ST_ACK2;
          end
        end
        ST_ACK2: begin
          if (scl_fall) begin
            state_d = nxt;
            cnt_d   = '0;
            oe_d    = (nxt == ST_RD) ? ~tx_sr[BYTE_W-1] : 1'b0;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              oe_d    = 1'b0;
              state_d = ST_RDACK;
            end else begin
              tx_d  = {tx_sr[BYTE_W-2:0], 1'b0};
              oe_d  = ~tx_sr[BYTE_W-2];
              cnt_d = cnt + CW'(1);
            end
          end
        end
        ST_RDACK: begin
          if (scl_rise) begin
            ackf_d = ~sda_now;
            if (!sda_now) begin
              mem_en    = 1'b1;
              ptr_inc   = 1'b1;
              rd_pend_d = 1'b1;
            end
          end
          if (scl_fall) begin
            cnt_d = '0;
            if (ackf) begin
              state_d = ST_RD;
              oe_d    = ~tx_sr[BYTE_W-1];
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state   <= ST_IDLE;
      nxt     <= ST_IDLE;
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      ackf    <= 1'b0;
      rd_pend <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      state   <= state_d;
      nxt     <= nxt_d;
      cnt     <= cnt_d;
      rx_sr   <= rx_d;
      tx_sr   <= tx_d;
      ackf    <= ackf_d;
      rd_pend <= rd_pend_d;
      sda_oe  <= oe_d;
    end
  end

endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
module i2c_eeprom_rd_chk
  import i2c_eeprom_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_ns,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          mem_en,
  input slv_state_e    state,
  input logic          start_det,
  input logic          ptr_ld,
  input logic [AW-1:0] ptr_ld_val,
  input logic          ptr_inc,
  input logic [AW-1:0] ptr
);

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_ns)
    (state == ST_IDLE) |-> !sda_oe); // R1

  AST_START_RESYNC: assert property (@(posedge clk) disable iff (!rst_ns)
    start_det |=> (state == ST_DEV)); // R2

  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_ns)
    (state == ST_IGNORE) |-> (!sda_oe && !mem_en)); // R4

  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_ns)
    ptr_ld |=> (ptr == $past(ptr_ld_val))); // R5

  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R6

  AST_PTR_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_ns)
    (ptr_inc && !ptr_ld) |=> (ptr == $past(ptr) + AW'(1))); // R8

endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .mem_en     (mem_en),
  .state      (state),
  .start_det  (start_det),
  .ptr_ld     (ptr_ld),
  .ptr_ld_val (ptr_ld_val),
  .ptr_inc    (ptr_inc),
  .ptr        (ptr)
);

// File: tb/test_i2c_eeprom_rd.sv
module test_i2c_eeprom_rd;

  localparam logic [6:0] DEV = 7'h50;
  localparam int Q = 20;

  logic       clk;
  logic       rst_n;
  logic       m_scl;
  logic       m_sda;
  logic       sda_bus;
  logic       sda_oe;
  logic       mem_en;
  logic       mem_we;
  logic [7:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int         exp_ptr;
  int         n_checks;
  int         n_errors;
  int         oe_cnt;
  int         acc_cnt;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_eeprom_rd i_i2c_eeprom_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_bus),
    .sda_oe    (sda_oe),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en) begin
      acc_cnt <= acc_cnt + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
    if (sda_oe) oe_cnt <= oe_cnt + 1;
  end

  function automatic logic [7:0] init_val(int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus;  tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack_low);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack_low);
  endtask

  task automatic get_byte(input bit mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(mack ? 1'b0 : 1'b1);
  endtask

  // read n bytes; from_addr < 0 means current-address read
  task automatic do_read(input int from_addr, input int n, input string req);
    logic       a;
    logic [7:0] d;
    bus_start();
    if (from_addr >= 0) begin
      put_byte({DEV, 1'b0}, a);
      check(a == 1'b0, "R3 write address ack", int'(a), 0);
      put_byte(8'(from_addr), a);
      check(a == 1'b0, "R5 word address ack", int'(a), 0);
      exp_ptr = from_addr;
      bus_start();
    end
    put_byte({DEV, 1'b1}, a);
    check(a == 1'b0, "R3 read address ack", int'(a), 0);
    for (int k = 0; k < n; k++) begin
      get_byte(k < n - 1, d);
      check(d == exp_mem[exp_ptr], req, int'(d), int'(exp_mem[exp_ptr]));
      exp_ptr = (exp_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic do_write(input int addr, input logic [7:0] v);
    logic a;
    bus_start();
    put_byte({DEV, 1'b0}, a);
    check(a == 1'b0, "R3 write address ack", int'(a), 0);
    put_byte(8'(addr), a);
    check(a == 1'b0, "R5 word address ack", int'(a), 0);
    put_byte(v, a);
    check(a == 1'b0, "R10 data ack", int'(a), 0);
    bus_stop();
    exp_mem[addr] = v;
    exp_ptr = (addr + 1) % 256;
    check(mem[addr] == v, "R10 memory written", int'(mem[addr]), int'(v));
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    repeat (190000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic       a;
    logic       b;
    logic [7:0] w;
    int         oe0;
    int         acc0;
    int         op;
    void'($urandom(32'd4711));
    for (int i = 0; i < 256; i++) begin
      mem[i]     = init_val(i);
      exp_mem[i] = init_val(i);
    end
    oe_cnt  = 0;
    acc_cnt = 0;
    exp_ptr = 0;
    m_scl   = 1'b1;
    m_sda   = 1'b1;
    rst_n   = 1'b0;
    tick(5);
    check(sda_oe == 1'b0, "R1 sda_oe in reset", int'(sda_oe), 0);
    check(mem_en == 1'b0, "R1 mem_en in reset", int'(mem_en), 0);
    rst_n = 1'b1;
    tick(10);
    check(sda_oe == 1'b0 && oe_cnt == 0, "R1 sda_oe after reset", oe_cnt, 0);
    check(acc_cnt == 0, "R1 no access after reset", acc_cnt, 0);

    // R6 random read, then R7 current read returns the next word
    do_read(8'h3C, 1, "R6 random read data");
    do_read(-1, 1, "R7 current read returns n+1");

    // R8 sequential read across the wrap
    do_read(8'hFE, 4, "R8 sequential read with wrap");
    do_read(-1, 1, "R7 current read after wrap");

    // R10 byte write, then R7 current read follows it
    w = 8'hA5;
    do_write(8'h10, w);
    do_read(-1, 1, "R7 current read after write");
    do_read(8'h10, 1, "R10 written byte reads back");

    // R2 aborted address byte, then a fresh START
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    do_read(-1, 2, "R2 read after restart");

    // R4 address mismatch
    oe0  = oe_cnt;
    acc0 = acc_cnt;
    bus_start();
    put_byte({7'h51, 1'b1}, a);
    check(a == 1'b1, "R4 mismatch not acked", int'(a), 1);
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      check(b == 1'b1, "R4 bus left high", int'(b), 1);
    end
    bus_stop();
    check(oe_cnt == oe0, "R4 no drive when ignored", oe_cnt - oe0, 0);
    check(acc_cnt == acc0, "R4 no memory access", acc_cnt - acc0, 0);
    do_read(-1, 1, "R4 pointer unchanged after mismatch");

    // R9 NACK releases the line
    bus_start();
    put_byte({DEV, 1'b1}, a);
    check(a == 1'b0, "R3 read address ack", int'(a), 0);
    get_byte(1'b0, w);
    check(w == exp_mem[exp_ptr], "R9 byte before NACK", int'(w), int'(exp_mem[exp_ptr]));
    exp_ptr = (exp_ptr + 1) % 256;
    oe0 = oe_cnt;
    for (int i = 0; i < 9; i++) get_bit(b);
    check(oe_cnt == oe0, "R9 no drive after NACK", oe_cnt - oe0, 0);
    bus_stop();
    check(sda_oe == 1'b0, "R9 released at idle", int'(sda_oe), 0);
    do_read(-1, 1, "R9 next current read");

    // random mix
    for (int it = 0; it < 12; it++) begin
      op = int'($urandom_range(2, 0));
      if (op == 0) begin
        do_read(int'($urandom_range(255, 0)), int'($urandom_range(3, 1)), "R6 random read data");
      end else if (op == 1) begin
        do_read(-1, int'($urandom_range(2, 1)), "R7 current read data");
      end else begin
        do_write(int'($urandom_range(255, 0)), 8'($urandom_range(255, 0)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule